// File: doc/BRIEF.md
# Per-Lane Vector Memory Address Generator

This block forms the memory address of every lane of one vector memory instruction. The instruction belongs to one of three classes: flat, scratch or global. Each instruction carries a 13-bit immediate offset, a 7-bit selector that names a scalar base, the 64-bit scalar base value that the selector names, one vector address operand per lane and an execution mask. From these the block returns one 64-bit address and one valid bit per lane.

The class sets how the immediate is read. A flat instruction uses only its low twelve bits, as an unsigned value. A scratch or global instruction reads all thirteen bits as a signed value, so the offset can point below the base. The selector sets how the address is built. When every selector bit is one, no scalar base is used and each lane takes its full 64-bit vector operand as the base. Any other selector value makes the scalar base common to all lanes, and each lane adds only the low 32 bits of its vector operand to that base.

A one-cycle start strobe captures the operands. On the next clock edge all lane results are registered together and a done pulse is raised. The results then hold until the next start.

Top module: `agen_top`

## Requirements
- R1: When class is 0 (flat), the offset added is the low 12 bits of the offset field, zero-extended. Bit 12 has no effect.
- R2: When class is 1 (scratch), 2 (global) or 3 (reserved, handled like global), the offset added is the 13-bit field sign-extended to 64 bits.
- R3: When the selector equals 7'h7F, an active lane's address is its full 64-bit vector operand plus the offset.
- R4: When the selector is any other value, an active lane's address is the scalar base plus the zero-extended low 32 bits of its vector operand plus the offset. Bits 63:32 of the operand have no effect.
- R5: A lane whose execution-mask bit is clear outputs address zero and valid 0. An active lane outputs valid 1.
- R6: Results for every lane update on the clock edge where start is sampled high, and done is high for exactly the cycle after that edge. Without start, the outputs hold their values and done is low.
- R7: After reset, every address is zero, every valid bit is 0 and done is 0.
- R8: All sums wrap modulo 2^64, and no overflow indication exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the operands and computes all lanes |
| cls_i | input | 2 | Instruction class: 0 flat, 1 scratch, 2 global, 3 treated as global |
| off_i | input | 13 | Immediate offset field |
| sel_i | input | 7 | Scalar base selector; 7'h7F means no scalar base |
| sbase_i | input | 64 | Scalar base value named by the selector |
| vaddr_i | input | NUM_LANES*64 | Vector operands, lane n at bits [64n+63:64n] |
| exec_i | input | NUM_LANES | Execution mask, one bit per lane |
| addr_o | output | NUM_LANES*64 | Lane addresses, lane n at bits [64n+63:64n] |
| lane_vld_o | output | NUM_LANES | Valid bit per lane |
| done_o | output | 1 | One-cycle pulse after a start |

## Verification
The hardest cases to reach from the ports are the edges of the offset range: bit 12 set under the flat class, where it must be dropped, and under the other classes, where it must make the offset negative. The same field values 0xFFF, 0x1000 and 0x1FFF are applied under all four class codes and both address modes, with all-zero, all-one and random masks. Negative offsets are also applied to bases near zero, and positive ones to bases near the top of the address space, so that both wraparound directions occur. Random vector operands with nonzero upper halves show whether the scalar-base mode discards those bits.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int ADDR_W = 64;
    localparam int OFF_W  = 13;
    localparam int SEL_W  = 7;
    localparam int VOFF_W = 32;
    localparam int CLS_W  = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_FLAT    = 2'd0,
        CLS_SCRATCH = 2'd1,
        CLS_GLOBAL  = 2'd2,
        CLS_RSVD    = 2'd3
    } mem_cls_e;
endpackage

// File: rtl/agen_off_interp.sv
module agen_off_interp
    import agen_pkg::*;
#(
    parameter int OFF_BITS  = OFF_W,
    parameter int ADDR_BITS = ADDR_W
) (
    input  mem_cls_e              cls_i,
    input  logic [OFF_BITS-1:0]   off_i,
    output logic [ADDR_BITS-1:0]  off_o
);
    localparam int UOFF_BITS = OFF_BITS - 1;

    always_comb begin
        unique case (cls_i)
            CLS_FLAT: off_o = {{(ADDR_BITS-UOFF_BITS){1'b0}}, off_i[UOFF_BITS-1:0]};
            default:  off_o = {{(ADDR_BITS-OFF_BITS){off_i[OFF_BITS-1]}}, off_i};
        endcase
    end
endmodule

// File: rtl/agen_mode_sel.sv
module agen_mode_sel
    import agen_pkg::*;
#(
    parameter int SEL_BITS = SEL_W
) (
    input  logic [SEL_BITS-1:0] sel_i,
    output logic                scalar_mode_o
);
    // all-ones selector means no scalar base
    always_comb scalar_mode_o = (sel_i != {SEL_BITS{1'b1}});
endmodule

// File: rtl/agen_lane.sv
module agen_lane
    import agen_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W,
    parameter int VOFF_BITS = VOFF_W
) (
    input  logic                 scalar_mode_i,
    input  logic                 active_i,
    input  logic [ADDR_BITS-1:0] sbase_i,
    input  logic [ADDR_BITS-1:0] vop_i,
    input  logic [ADDR_BITS-1:0] off_i,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic                 vld_o
);
    logic [ADDR_BITS-1:0] base;
    logic [ADDR_BITS-1:0] index;

    always_comb begin
        if (scalar_mode_i) begin
            base  = sbase_i;
            index = {{(ADDR_BITS-VOFF_BITS){1'b0}}, vop_i[VOFF_BITS-1:0]};
        end else begin
            base  = vop_i;
            index = '0;
        end
        vld_o  = active_i;
        addr_o = active_i ? (base + index + off_i) : '0;
    end
endmodule

// File: rtl/agen_top.sv
module agen_top
    import agen_pkg::*;
#(
    parameter int NUM_LANES = 64,
    parameter int ADDR_BITS = ADDR_W,
    parameter int OFF_BITS  = OFF_W,
    parameter int SEL_BITS  = SEL_W,
    parameter int VOFF_BITS = VOFF_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [CLS_W-1:0]               cls_i,
    input  logic [OFF_BITS-1:0]            off_i,
    input  logic [SEL_BITS-1:0]            sel_i,
    input  logic [ADDR_BITS-1:0]           sbase_i,
    input  logic [NUM_LANES*ADDR_BITS-1:0] vaddr_i,
    input  logic [NUM_LANES-1:0]           exec_i,
    output logic [NUM_LANES*ADDR_BITS-1:0] addr_o,
    output logic [NUM_LANES-1:0]           lane_vld_o,
    output logic                           done_o
);
    localparam int VEC_BITS = NUM_LANES * ADDR_BITS;

    typedef struct packed {
        logic                 done;
        logic [NUM_LANES-1:0] vld;
        logic [VEC_BITS-1:0]  addr;
    } agen_state_t;

    agen_state_t          st_d, st_q;
    logic [ADDR_BITS-1:0] off_ext;
    logic                 scalar_mode;
    logic [VEC_BITS-1:0]  lane_addr;
    logic [NUM_LANES-1:0] lane_vld;

    agen_off_interp #(.OFF_BITS(OFF_BITS), .ADDR_BITS(ADDR_BITS)) i_off (
        .cls_i (mem_cls_e'(cls_i)),
        .off_i (off_i),
        .off_o (off_ext)
    );

    agen_mode_sel #(.SEL_BITS(SEL_BITS)) i_mode (
        .sel_i         (sel_i),
        .scalar_mode_o (scalar_mode)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        agen_lane #(.ADDR_BITS(ADDR_BITS), .VOFF_BITS(VOFF_BITS)) i_lane (
            .scalar_mode_i (scalar_mode),
            .active_i      (exec_i[g]),
            .sbase_i       (sbase_i),
            .vop_i         (vaddr_i[g*ADDR_BITS +: ADDR_BITS]),
            .off_i         (off_ext),
            .addr_o        (lane_addr[g*ADDR_BITS +: ADDR_BITS]),
            .vld_o         (lane_vld[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.vld  = lane_vld;
            st_d.addr = lane_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o     = st_q.addr;
    assign lane_vld_o = st_q.vld;
    assign done_o     = st_q.done;
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
    parameter int NUM_LANES = 64,
    parameter int ADDR_BITS = 64,
    parameter int OFF_BITS  = 13,
    parameter int SEL_BITS  = 7,
    parameter int VOFF_BITS = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           start_i,
    input logic [1:0]                     cls_i,
    input logic [OFF_BITS-1:0]            off_i,
    input logic [SEL_BITS-1:0]            sel_i,
    input logic [ADDR_BITS-1:0]           sbase_i,
    input logic [NUM_LANES*ADDR_BITS-1:0] vaddr_i,
    input logic [NUM_LANES-1:0]           exec_i,
    input logic [NUM_LANES*ADDR_BITS-1:0] addr_o,
    input logic [NUM_LANES-1:0]           lane_vld_o,
    input logic                           done_o
);
    localparam logic [SEL_BITS-1:0]  SEL_NONE = {SEL_BITS{1'b1}};
    localparam logic [ADDR_BITS-1:0] U_SPAN   = ADDR_BITS'(1) << (OFF_BITS - 1);
    localparam logic [ADDR_BITS-1:0] S_SPAN   = ADDR_BITS'(1) << OFF_BITS;

    logic [ADDR_BITS-1:0] v0, a0, v0_lo;
    assign v0    = vaddr_i[ADDR_BITS-1:0];
    assign a0    = addr_o[ADDR_BITS-1:0];
    assign v0_lo = {{(ADDR_BITS-VOFF_BITS){1'b0}}, v0[VOFF_BITS-1:0]};

    p_flat_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && cls_i == 2'd0 && sel_i == SEL_NONE && exec_i[0]
        |=> (a0 - $past(v0)) < U_SPAN);

    p_signed_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && cls_i != 2'd0 && sel_i == SEL_NONE && exec_i[0]
        |=> (a0 - $past(v0) + U_SPAN) < S_SPAN);

    p_scalar_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && sel_i != SEL_NONE && exec_i[0]
        |=> (a0 - $past(sbase_i) - $past(v0_lo) + U_SPAN) < S_SPAN);

    p_valid_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> lane_vld_o == $past(exec_i));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_zero
        p_idle_lane_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_vld_o[g] |-> addr_o[g*ADDR_BITS +: ADDR_BITS] == '0);
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o && $stable(addr_o) && $stable(lane_vld_o));
endmodule

bind agen_top agen_checker #(
    .NUM_LANES (NUM_LANES),
    .ADDR_BITS (ADDR_BITS),
    .OFF_BITS  (OFF_BITS),
    .SEL_BITS  (SEL_BITS),
    .VOFF_BITS (VOFF_BITS)
) i_agen_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cls_i      (cls_i),
    .off_i      (off_i),
    .sel_i      (sel_i),
    .sbase_i    (sbase_i),
    .vaddr_i    (vaddr_i),
    .exec_i     (exec_i),
    .addr_o     (addr_o),
    .lane_vld_o (lane_vld_o),
    .done_o     (done_o)
);

// File: tb/test_agen_top.sv
module test_agen_top;
    localparam int  NL      = 64;
    localparam time CLK_PER = 10ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [1:0]     cls_i = '0;
    logic [12:0]    off_i = '0;
    logic [6:0]     sel_i = '0;
    logic [63:0]    sbase_i = '0;
    logic [NL*64-1:0] vaddr_i = '0;
    logic [NL-1:0]  exec_i = '0;
    logic [NL*64-1:0] addr_o;
    logic [NL-1:0]  lane_vld_o;
    logic           done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PER/2) clk = ~clk;

    agen_top #(.NUM_LANES(NL)) i_agen_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cls_i(cls_i),
        .off_i(off_i), .sel_i(sel_i), .sbase_i(sbase_i), .vaddr_i(vaddr_i),
        .exec_i(exec_i), .addr_o(addr_o), .lane_vld_o(lane_vld_o), .done_o(done_o)
    );

    // offset value from R1 / R2
    function automatic logic [63:0] exp_off(logic [1:0] c, logic [12:0] o);
        if (c == 2'd0) return {52'b0, o[11:0]};
        return {{51{o[12]}}, o};
    endfunction

    // lane address from R3 / R4 / R5 / R8
    function automatic logic [63:0] exp_addr(logic [1:0] c, logic [12:0] o, logic [6:0] s,
                                             logic [63:0] sb, logic [63:0] v, logic act);
        if (!act) return 64'd0;
        if (s == 7'h7F) return v + exp_off(c, o);
        return sb + {32'b0, v[31:0]} + exp_off(c, o);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply one instruction and compare all lanes
    task automatic run(string req, logic [1:0] c, logic [12:0] o, logic [6:0] s,
                       logic [63:0] sb, logic [NL-1:0] m);
        logic [NL*64-1:0] v_snap;
        @(negedge clk);
        cls_i = c; off_i = o; sel_i = s; sbase_i = sb; exec_i = m;
        start_i = 1'b1;
        v_snap = vaddr_i;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R6 done"}, 64'(done_o), 64'd1);
        for (int l = 0; l < NL; l++) begin
            check(req, addr_o[l*64 +: 64],
                  exp_addr(c, o, s, sb, v_snap[l*64 +: 64], m[l]));
            check({req, " R5 valid"}, 64'(lane_vld_o[l]), 64'(m[l]));
        end
    endtask

    task automatic rand_vaddr();
        for (int l = 0; l < NL; l++) vaddr_i[l*64 +: 64] = {$urandom(), $urandom()};
    endtask

    function automatic logic [NL-1:0] rand_mask();
        logic [NL-1:0] r;
        for (int l = 0; l < NL; l++) r[l] = 1'($urandom());
        return r;
    endfunction

    initial begin
        #(CLK_PER * 40000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [12:0]   offs [3];
        logic [6:0]    sels [2];
        logic [NL-1:0] mk;
        logic [NL*64-1:0] held_a;
        logic [NL-1:0]    held_v;
        void'($urandom(32'h5EED_0A11));
        offs[0] = 13'h0FFF; offs[1] = 13'h1000; offs[2] = 13'h1FFF;
        sels[0] = 7'h7F;    sels[1] = 7'h05;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7 reset state
        check("R7 done", 64'(done_o), 64'd0);
        check("R7 valid", 64'(lane_vld_o), 64'd0);
        for (int l = 0; l < NL; l++) check("R7 addr", addr_o[l*64 +: 64], 64'd0);
        rst_n = 1'b1;

        // directed: offsets x classes x modes x masks (R1 R2 R3 R4 R5)
        for (int c = 0; c < 4; c++)
            for (int oi = 0; oi < 3; oi++)
                for (int si = 0; si < 2; si++)
                    for (int mi = 0; mi < 3; mi++) begin
                        rand_vaddr();
                        mk = (mi == 0) ? '0 : (mi == 1) ? '1 : rand_mask();
                        run((c == 0) ? "R1 flat" : (si == 0 ? "R2 R3 signed" : "R2 R4 signed"),
                            2'(c), offs[oi], sels[si], {$urandom(), $urandom()}, mk);
                    end

        // R8 wraparound: negative offset under small bases, positive near the top
        for (int l = 0; l < NL; l++) vaddr_i[l*64 +: 64] = 64'(l);
        run("R8 R3 wrap low", 2'd2, 13'h1000, 7'h7F, 64'd0, '1);
        for (int l = 0; l < NL; l++) vaddr_i[l*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(l);
        run("R8 R1 wrap high", 2'd0, 13'h0FFF, 7'h7F, 64'd0, '1);
        for (int l = 0; l < NL; l++) vaddr_i[l*64 +: 64] = {32'hDEAD_BEEF, 32'hFFFF_FFF0 + 32'(l)};
        run("R8 R4 wrap scalar", 2'd1, 13'h0FFF, 7'h00, 64'hFFFF_FFFF_0000_0000, '1);

        // R6 hold: no start, change inputs, outputs keep values
        held_a = addr_o; held_v = lane_vld_o;
        @(negedge clk);
        rand_vaddr(); exec_i = ~exec_i; off_i = ~off_i; sbase_i = ~sbase_i;
        @(negedge clk);
        check("R6 done low", 64'(done_o), 64'd0);
        check("R6 valid hold", 64'(lane_vld_o), 64'(held_v));
        for (int l = 0; l < NL; l++) check("R6 addr hold", addr_o[l*64 +: 64], held_a[l*64 +: 64]);

        // random mix
        for (int k = 0; k < 200; k++) begin
            rand_vaddr();
            run("R3 R4 random", 2'($urandom()), 13'($urandom()),
                (($urandom() & 3) == 0) ? 7'h7F : 7'($urandom()),
                {$urandom(), $urandom()}, rand_mask());
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule